// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execution unit for the register-to-register and register-to-immediate group of a 32-bit RISC core. A 4-bit operation code picks one of sixteen operations. Eight are logical (AND, XOR, OR, move, bit-clear, move-inverted, plus the test-AND and test-XOR forms). Eight are arithmetic (add, subtract, reverse subtract, the three carry-chained forms, compare and compare-negative). The second operand arrives already shifted or rotated. The shifter's carry-out is supplied on its own pin so that the logical operations can pass it on into the carry flag.

The result and the register-write enable are combinational. The next negative, zero, carry and overflow flags are also combinational. A small flag holder keeps the current flags. It loads the next flags on a clock edge whenever flag setting is enabled, and it supplies the carry used by the chained forms. Because of this, multi-word add and subtract sequences can be issued back to back, one operation per cycle.

Top module: `dpalu_core`

## Requirements
- R1: The logical operation codes produce these results: 0x0 gives A AND B, 0x1 gives A XOR B, 0xC gives A OR B, 0xD gives B, 0xE gives A AND NOT B, and 0xF gives NOT B.
- R2: Code 0x4 gives A+B, code 0x2 gives A−B and code 0x3 gives B−A, each modulo 2^32. Codes 0xA and 0xB compute A−B and A+B for the flags only.
- R3: `wr_en` is low for codes 0x8, 0x9, 0xA and 0xB, and high for every other code.
- R4: Code 0x5 gives A+B+C. Code 0x6 gives A−B−(1−C) and code 0x7 gives B−A−(1−C). C is the held carry: bit 29 of the status word, which is bit 1 of `status_q`.
- R5: For the arithmetic codes, the next C is the unsigned carry-out of an addition. For a subtraction it is NOT borrow, taken in the operand order actually used, so the reverse forms use B as the minuend.
- R6: For the arithmetic codes, the next V is set when the signed result, in the operand order used, cannot be represented in 32 bits.
- R7: The next N equals bit 31 of the computed result, and the next Z is set exactly when the computed result is zero. This includes codes 0x8 to 0xB.
- R8: For the logical codes (0x0, 0x1, 0x8, 0x9, 0xC to 0xF), the next C equals `shift_cout` and the next V equals the held V.
- R9: When `flag_we` is low, `nxt_flags` equals `status_q` and the holder keeps its value. When `flag_we` is high, `status_q` takes `nxt_flags` at the next rising clock edge. The nibble order is {N,Z,C,V}, which matches status word bits 31 to 28.
- R10: While `rst_n` is low, `status_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag holder |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| shift_cout | input | 1 | Carry-out of the shifter |
| flag_we | input | 1 | Set-flags enable |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| nxt_flags | output | 4 | Next {N,Z,C,V} |
| status_q | output | 4 | Held {N,Z,C,V} |

## Verification
Two functions can act in the same cycle: the consumption of the held carry by a chained add or subtract, and the update of that same carry by the operation's own flag result. Runs of consecutive carry-chained operations with `flag_we` high provoke this overlap. Directed 64-bit add and subtract chains are used, along with random streams where the chained codes are dense. A bench model that tracks the holder judges each cycle: the result must use the old carry, and `status_q` must show the new carry only after the edge.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  localparam int STATUS_CARRY_BIT = 29;
  localparam int STATUS_FLAG_BASE = 28;
  localparam int NFLAGS           = 4;

  typedef enum logic [3:0] {
    OP_AND  = 4'h0, OP_XOR  = 4'h1, OP_SUB  = 4'h2, OP_RSB  = 4'h3,
    OP_ADD  = 4'h4, OP_ADC  = 4'h5, OP_SBC  = 4'h6, OP_RSC  = 4'h7,
    OP_TAND = 4'h8, OP_TXOR = 4'h9, OP_CMP  = 4'hA, OP_CMN  = 4'hB,
    OP_OR   = 4'hC, OP_MOV  = 4'hD, OP_BIC  = 4'hE, OP_MVN  = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {CIN_ZERO = 2'd0, CIN_ONE = 2'd1, CIN_FLAG = 2'd2} cin_sel_e;

  typedef struct packed {
    logic     is_arith;
    logic     swap;
    logic     inv_y;
    cin_sel_e cin_sel;
    logic     wr;
  } alu_ctrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/dpalu_decode.sv
module dpalu_decode
  import dpalu_pkg::*;
(
  input  alu_op_e   op,
  output alu_ctrl_t ctrl
);
  always_comb begin
    ctrl          = '0;
    ctrl.cin_sel  = CIN_ZERO;
    ctrl.wr       = (op[3:2] != 2'b10);
    case (op)
      OP_ADD, OP_CMN: begin ctrl.is_arith = 1'b1; end
      OP_ADC:         begin ctrl.is_arith = 1'b1; ctrl.cin_sel = CIN_FLAG; end
      OP_SUB, OP_CMP: begin ctrl.is_arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_ONE; end
      OP_SBC:         begin ctrl.is_arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_FLAG; end
      OP_RSB:         begin ctrl.is_arith = 1'b1; ctrl.swap = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_ONE; end
      OP_RSC:         begin ctrl.is_arith = 1'b1; ctrl.swap = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_FLAG; end
      default:        begin ctrl.is_arith = 1'b0; end
    endcase
  end
endmodule

// File: rtl/dpalu_addsub.sv
module dpalu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] full;
  always_comb begin
    full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
    ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_TAND: res = a & b;
      OP_XOR, OP_TXOR: res = a ^ b;
      OP_OR:           res = a | b;
      OP_MOV:          res = b;
      OP_BIC:          res = a & ~b;
      OP_MVN:          res = ~b;
      default:         res = '0;
    endcase
  end
endmodule

// File: rtl/dpalu_flagreg.sv
module dpalu_flagreg
  import dpalu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  flags_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));
endmodule

// File: rtl/dpalu_core.sv
module dpalu_core
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              shift_cout,
  input  logic              flag_we,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [NFLAGS-1:0] nxt_flags,
  output logic [NFLAGS-1:0] status_q
);
  localparam int CPOS = STATUS_CARRY_BIT - STATUS_FLAG_BASE;

  alu_op_e           op;
  alu_ctrl_t         ctrl;
  flags_t            held, calc, nxt;
  logic [DATA_W-1:0] x, y_raw, y, arith_res, logic_res, res;
  logic              cin, a_cout, a_ovf;

  assign op = alu_op_e'(op_code);

  dpalu_decode u_dec (.op(op), .ctrl(ctrl));

  always_comb begin
    x     = ctrl.swap ? opnd_b : opnd_a;
    y_raw = ctrl.swap ? opnd_a : opnd_b;
    y     = ctrl.inv_y ? ~y_raw : y_raw;
    case (ctrl.cin_sel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = held.c;
      default:  cin = 1'b0;
    endcase
  end

  dpalu_addsub #(.W(DATA_W)) u_add (
    .x(x), .y(y), .cin(cin), .sum(arith_res), .cout(a_cout), .ovf(a_ovf));

  dpalu_logic #(.W(DATA_W)) u_log (
    .op(op), .a(opnd_a), .b(opnd_b), .res(logic_res));

  always_comb begin
    res    = ctrl.is_arith ? arith_res : logic_res;
    calc.n = res[DATA_W-1];
    calc.z = (res == '0);
    calc.c = ctrl.is_arith ? a_cout : shift_cout;
    calc.v = ctrl.is_arith ? a_ovf  : held.v;
    nxt    = flag_we ? calc : held;
  end

  dpalu_flagreg u_flags (.clk(clk), .rst_n(rst_n), .load(flag_we), .d(nxt), .q(held));

  assign result    = res;
  assign wr_en     = ctrl.wr;
  assign nxt_flags = nxt;
  assign status_q  = held;

  p_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code[3:2] == 2'b10) |-> !wr_en);
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (nxt_flags[2] == (result == '0)) && (nxt_flags[3] == result[DATA_W-1]));
  p_logic_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !ctrl.is_arith) |-> (nxt_flags[0] == status_q[0]) && (nxt_flags[CPOS] == shift_cout));
  p_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |-> (nxt_flags == status_q));
endmodule

// File: tb/dpalu_core_bench.sv
module dpalu_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic        shift_cout, flag_we;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  nxt_flags, status_q;

  int checks = 0;
  int bad    = 0;
  logic [3:0] m_flags;

  always #2 clk = ~clk;

  dpalu_core u_dpalu_core (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h op=%h a=%h b=%h", tag, act, exp, op_code, opnd_a, opnd_b);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic [3:0] fin,
                       output logic [31:0] r, output logic w, output logic [3:0] f);
    longint sp, sq, sv;
    logic [32:0] full;
    logic c, v, ci;
    logic [31:0] p, q;
    ci = fin[1];
    w  = !(op >= 4'h8 && op <= 4'hB);
    p  = (op == 4'h3 || op == 4'h7) ? b : a;
    q  = (op == 4'h3 || op == 4'h7) ? a : b;
    sp = longint'(signed'(p));
    sq = longint'(signed'(q));
    c  = sc; v = fin[0];
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hD: r = b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'h4, 4'hB, 4'h5: begin
        logic k; k = (op == 4'h5) ? ci : 1'b0;
        full = {1'b0, p} + {1'b0, q} + {32'd0, k};
        r = full[31:0]; c = full[32];
        sv = sp + sq + longint'(k);
        v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      default: begin
        logic bi; bi = (op == 4'h6 || op == 4'h7) ? !ci : 1'b0;
        r = p - q - {31'd0, bi};
        c = ({1'b0, p} >= ({1'b0, q} + {32'd0, bi}));
        sv = sp - sq - longint'(bi);
        v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
    endcase
    f = {r[31], (r == 32'd0), c, v};
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sc, input logic fwe);
    logic [31:0] er; logic ew; logic [3:0] ef, en;
    string rtag, ctag, vtag;
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; shift_cout = sc; flag_we = fwe;
    #1;
    model(op, a, b, sc, m_flags, er, ew, ef);
    en = fwe ? ef : m_flags;
    rtag = (op inside {4'h5, 4'h6, 4'h7}) ? "R4" :
           (op inside {4'h2, 4'h3, 4'h4, 4'hA, 4'hB}) ? "R2" : "R1";
    ctag = (op inside {[4'h2:4'h7], 4'hA, 4'hB}) ? "R5" : "R8";
    vtag = (op inside {[4'h2:4'h7], 4'hA, 4'hB}) ? "R6" : "R8";
    if (op inside {[4'h8:4'hB]}) chk("R7 result (flags-only code)", result, er);
    else chk(rtag, result, er);
    chk("R3 wr_en", {31'd0, wr_en}, {31'd0, ew});
    if (fwe) begin
      chk("R7 N/Z", {30'd0, nxt_flags[3:2]}, {30'd0, en[3:2]});
      chk(ctag, {31'd0, nxt_flags[1]}, {31'd0, en[1]});
      chk(vtag, {31'd0, nxt_flags[0]}, {31'd0, en[0]});
    end else begin
      chk("R9 nxt_flags held", {28'd0, nxt_flags}, {28'd0, m_flags});
    end
    @(posedge clk); #1;
    m_flags = en;
    chk("R9 status_q", {28'd0, status_q}, {28'd0, m_flags});
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; op_code = 4'h0; opnd_a = '0; opnd_b = '0; shift_cout = 1'b0; flag_we = 1'b0;
    m_flags = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset status_q", {28'd0, status_q}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R5/R6 directed: overflow and carry-out
    step(4'h4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
    step(4'h4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
    // R4 chain: carry set above, ADC consumes it while producing new flags
    step(4'h5, 32'h0, 32'h0, 1'b0, 1'b1);
    // R4 SBC with carry clear subtracts one more
    step(4'h2, 32'h3, 32'h5, 1'b0, 1'b1);
    step(4'h6, 32'h5, 32'h3, 1'b0, 1'b1);
    step(4'h7, 32'h5, 32'h3, 1'b0, 1'b1);
    // R2 reverse order, R3 compare does not write
    step(4'h3, 32'h3, 32'h5, 1'b0, 1'b1);
    step(4'hA, 32'h8000_0000, 32'h1, 1'b0, 1'b1);
    step(4'hB, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b1);
    // R8 logical: carry from shifter, V kept
    step(4'h4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
    step(4'hD, 32'h0, 32'h0, 1'b1, 1'b1);
    step(4'h9, 32'h1234, 32'h1234, 1'b0, 1'b1);
    // R9 flag_we low keeps holder
    step(4'h2, 32'h0, 32'h1, 1'b1, 1'b0);
    // 64-bit add and subtract chains
    step(4'h4, 32'hFFFF_FFF0, 32'h20, 1'b0, 1'b1);
    step(4'h5, 32'h1, 32'h2, 1'b0, 1'b1);
    step(4'h2, 32'h0, 32'h1, 1'b0, 1'b1);
    step(4'h6, 32'h10, 32'h1, 1'b0, 1'b1);
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op; logic [31:0] a, b;
      op = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 2) == 0) op = 4'($urandom_range(5, 7));
      a = $urandom; b = $urandom;
      if ($urandom_range(0, 7) == 0) b = a;
      if ($urandom_range(0, 7) == 0) a = 32'h8000_0000;
      step(op, a, b, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule